// File: doc/BRIEF.md
# Calendar Time Counter with Alarm

This block keeps wall-clock time and a calendar date. A fast base enable, normally pulsing at 32.768 kHz, drives a sub-second prescaler. The prescaler produces one advance per second. Each advance steps a cascade of packed-BCD fields: seconds, minutes, hours, day of month, weekday, month and a two-digit year. The day of month wraps according to the length of the current month and a leap-year rule. When the year wraps from 99 to 00, a century bit kept beside the month toggles.

Software reaches every field through a byte-wide register port with a 4-bit index. A write lands on the clock edge, and a read is combinational from the index. Four alarm bytes (minute, hour, day, weekday) each carry an active-low enable in bit 7. When the enabled fields become equal to the current time, a sticky alarm flag is set. An active-low interrupt output follows that flag until software clears it.

A write to a field replaces that field's update for that cycle only; the other fields still follow the tick. Writing the seconds field also restarts the prescaler, so the next advance comes a full second after the write.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, time is 00:00:00, day 01h, weekday 0, month 01h, century bit 0, year 00h, all four alarm bytes 80h (disabled), and the alarm flag is clear.
- R2: The seconds field advances exactly once per TICK_DIV base-enable pulses and holds otherwise.
- R3: A write to index 2 (seconds) restarts the prescaler, so the next advance needs a full TICK_DIV further base-enable pulses.
- R4: Seconds and minutes count 00h to 59h in BCD; at 59h they wrap to 00h and carry into the next field.
- R5: Hours count 00h to 23h; wrapping from 23h carries into the day of month and the weekday; the weekday counts 0 to 6 and wraps to 0.
- R6: The day of month wraps to 01h after 30h in months 04h, 06h, 09h and 11h, and after 31h in months 01h, 03h, 05h, 07h, 08h, 10h and 12h, carrying into the month.
- R7: In month 02h the day wraps after 29h when the year is a multiple of four (00 included), and after 28h otherwise.
- R8: The month wraps from 12h to 01h and carries into the year; the year wraps from 99h to 00h and toggles the century bit, which is bit 7 of index 7.
- R9: Register map: index 1 holds the flag in bit 3. Index 2 holds seconds (bits 6:0) and index 3 minutes (bits 6:0). Index 4 holds hours (bits 5:0) and index 5 the day (bits 5:0). Index 6 holds the weekday (bits 2:0). Index 7 holds the century in bit 7 and the month in bits 4:0. Index 8 holds the year. Indices 9 to 12 hold the alarm minute, hour, day and weekday as full bytes. Unlisted bits and indices read 0.
- R10: Bit 7 of an alarm byte set to 0 enables that field. The alarm minute compares bits 6:0, the hour and day compare bits 5:0, and the weekday compares bits 2:0. The flag sets one cycle after the match of all enabled fields turns from false to true. With no field enabled, the flag never sets.
- R11: The flag stays set until a write to index 1 with bit 3 at 0 clears it; writing 1 there has no effect, and a match that is still present after clearing does not set it again.
- R12: The output irq_n is low exactly while the alarm flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_en | input | 1 | Base-rate enable pulse feeding the prescaler |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register index for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register at addr |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The bench drives the clock through each boundary of the cascade: 23:59:58 at the end of a non-leap February, the end of a leap February, the end of a 30-day month, and 31 December of year 99, crossed twice. A design with a wrong month-length table or a wrong leap test shows the wrong day one second later. A design with an inverted century update leaves bit 7 of index 7 stuck. The bench writes the seconds field in the middle of a second and counts pulses to the next advance, which exposes a prescaler that is not restarted. The alarm tests use a disabled field holding a value that does not match, clear the flag while the match is still present, and write 1 to the flag bit. These tests catch a design that compares disabled fields, sets the flag on level instead of edge, or clears the flag on any write.

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
  parameter int TICK_DIV = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       base_en,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq_n
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] presc;
  logic [6:0] sec, min;
  logic [5:0] hr, day;
  logic [2:0] wd;
  logic [4:0] mon;
  logic       cent;
  logic [7:0] yr;
  logic [7:0] a_min, a_hr, a_day, a_wd;
  logic       flag, match_q;

  function automatic logic [7:0] binc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic w_sec, w_min, w_hr, w_day, w_wd, w_mon, w_yr;
  assign w_sec = wr_en && addr == 4'h2;
  assign w_min = wr_en && addr == 4'h3;
  assign w_hr  = wr_en && addr == 4'h4;
  assign w_day = wr_en && addr == 4'h5;
  assign w_wd  = wr_en && addr == 4'h6;
  assign w_mon = wr_en && addr == 4'h7;
  assign w_yr  = wr_en && addr == 4'h8;

  logic tick;
  assign tick = base_en && !w_sec && presc == PLAST;

  logic leap;
  assign leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                      : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);

  logic [5:0] dim;
  always_comb begin
    if (mon == 5'h02)
      dim = leap ? 6'h29 : 6'h28;
    else if (mon == 5'h04 || mon == 5'h06 || mon == 5'h09 || mon == 5'h11)
      dim = 6'h30;
    else
      dim = 6'h31;
  end

  logic c_min, c_hr, c_day, c_mon, c_yr;
  assign c_min = tick && sec == 7'h59;
  assign c_hr  = c_min && min == 7'h59;
  assign c_day = c_hr && hr == 6'h23;
  assign c_mon = c_day && day == dim;
  assign c_yr  = c_mon && mon == 5'h12;

  logic [7:0] sec_i, min_i, hr_i, day_i, mon_i, yr_i;
  assign sec_i = binc({1'b0, sec});
  assign min_i = binc({1'b0, min});
  assign hr_i  = binc({2'b0, hr});
  assign day_i = binc({2'b0, day});
  assign mon_i = binc({3'b0, mon});
  assign yr_i  = binc(yr);

  logic match;
  assign match = !(a_min[7] && a_hr[7] && a_day[7] && a_wd[7])
              && (a_min[7] || a_min[6:0] == min)
              && (a_hr[7]  || a_hr[5:0]  == hr)
              && (a_day[7] || a_day[5:0] == day)
              && (a_wd[7]  || a_wd[2:0]  == wd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      sec <= '0; min <= '0; hr <= '0; day <= 6'h01; wd <= '0;
      mon <= 5'h01; cent <= 1'b0; yr <= '0;
      a_min <= 8'h80; a_hr <= 8'h80; a_day <= 8'h80; a_wd <= 8'h80;
      flag <= 1'b0; match_q <= 1'b0;
    end else begin
      if (w_sec)        presc <= '0;
      else if (base_en) presc <= tick ? '0 : presc + 1'b1;

      if (w_sec)      sec <= wdata[6:0];
      else if (tick)  sec <= (sec == 7'h59) ? 7'h00 : sec_i[6:0];
      if (w_min)      min <= wdata[6:0];
      else if (c_min) min <= (min == 7'h59) ? 7'h00 : min_i[6:0];
      if (w_hr)       hr <= wdata[5:0];
      else if (c_hr)  hr <= (hr == 6'h23) ? 6'h00 : hr_i[5:0];
      if (w_day)      day <= wdata[5:0];
      else if (c_day) day <= (day == dim) ? 6'h01 : day_i[5:0];
      if (w_wd)       wd <= wdata[2:0];
      else if (c_day) wd <= (wd == 3'd6) ? 3'd0 : wd + 3'd1;
      if (w_mon)      mon <= wdata[4:0];
      else if (c_mon) mon <= (mon == 5'h12) ? 5'h01 : mon_i[4:0];
      if (w_mon)      cent <= wdata[7];
      else if (c_yr && yr == 8'h99) cent <= ~cent;
      if (w_yr)       yr <= wdata;
      else if (c_yr)  yr <= (yr == 8'h99) ? 8'h00 : yr_i;

      if (wr_en && addr == 4'h9) a_min <= wdata;
      if (wr_en && addr == 4'hA) a_hr  <= wdata;
      if (wr_en && addr == 4'hB) a_day <= wdata;
      if (wr_en && addr == 4'hC) a_wd  <= wdata;

      match_q <= match;
      if (match && !match_q)                          flag <= 1'b1;
      else if (wr_en && addr == 4'h1 && !wdata[3])    flag <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      4'h1:    rdata = {4'b0, flag, 3'b0};
      4'h2:    rdata = {1'b0, sec};
      4'h3:    rdata = {1'b0, min};
      4'h4:    rdata = {2'b0, hr};
      4'h5:    rdata = {2'b0, day};
      4'h6:    rdata = {5'b0, wd};
      4'h7:    rdata = {cent, 2'b0, mon};
      4'h8:    rdata = yr;
      4'h9:    rdata = a_min;
      4'hA:    rdata = a_hr;
      4'hB:    rdata = a_day;
      4'hC:    rdata = a_wd;
      default: rdata = 8'h00;
    endcase
  end

  assign irq_n = ~flag;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [3:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       irq_n,
  input logic       tick,
  input logic [6:0] sec,
  input logic [7:0] yr,
  input logic       cent,
  input logic       flag,
  input logic       match
);
  // R2
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !(wr_en && addr == 4'h2) |=> $stable(sec));

  // R4
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && sec == 7'h59 |=> sec == 7'h00);

  // R8
  cent_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cent != $past(cent)) && !$past(wr_en && addr == 4'h7) |-> $past(yr) == 8'h99);

  // R10
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(match));

  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !(wr_en && addr == 4'h1 && !wdata[3]) |=> flag);

  // R12
  irq_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 4'h1 |-> irq_n == !rdata[3]);
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .irq_n(irq_n), .tick(tick), .sec(sec), .yr(yr),
  .cent(cent), .flag(flag), .match(match)
);

// File: tb/tb_rtc_calendar.sv
module tb_rtc_calendar;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_en = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic irq_n;

  always #4 clk = ~clk;

  rtc_calendar #(.TICK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .base_en(base_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  int total = 0, errs = 0, cycles = 0;
  bit done = 0;

  int m_sec, m_min, m_hr, m_day, m_wd, m_mon, m_yr, m_cent, m_presc, m_flag, m_pm;
  logic [7:0] m_al [4];

  function automatic int bcd(int v); return ((v / 10) << 4) | (v % 10); endfunction
  function automatic int bin(int b); return ((b >> 4) & 15) * 10 + (b & 15); endfunction
  function automatic int days_in(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_read(logic [3:0] a);
    case (a)
      4'h1: return m_flag ? 8'h08 : 8'h00;
      4'h2: return 8'(bcd(m_sec));
      4'h3: return 8'(bcd(m_min));
      4'h4: return 8'(bcd(m_hr));
      4'h5: return 8'(bcd(m_day));
      4'h6: return 8'(m_wd);
      4'h7: return 8'((m_cent << 7) | bcd(m_mon));
      4'h8: return 8'(bcd(m_yr));
      4'h9: return m_al[0];
      4'hA: return m_al[1];
      4'hB: return m_al[2];
      4'hC: return m_al[3];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] a);
    case (a)
      4'h1: return "R11";
      4'h2: return "R2";
      4'h3: return "R4";
      4'h4, 4'h6: return "R5";
      4'h5: return "R6";
      4'h7, 4'h8: return "R8";
      4'h9, 4'hA, 4'hB, 4'hC: return "R10";
      default: return "R9";
    endcase
  endfunction

  function automatic bit model_match();
    bit any;
    any = !(m_al[0][7] && m_al[1][7] && m_al[2][7] && m_al[3][7]);
    return any
      && (m_al[0][7] || int'(m_al[0][6:0]) == bcd(m_min))
      && (m_al[1][7] || int'(m_al[1][5:0]) == bcd(m_hr))
      && (m_al[2][7] || int'(m_al[2][5:0]) == bcd(m_day))
      && (m_al[3][7] || int'(m_al[3][2:0]) == m_wd);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_wd = 0; m_mon = 1;
      m_yr = 0; m_cent = 0; m_presc = 0; m_flag = 0; m_pm = 0;
      for (int i = 0; i < 4; i++) m_al[i] = 8'h80;
    end else begin
      bit m, t, cm, ch, cd, cmo, cy;
      m = model_match();
      t = 0;
      if (wr_en && addr == 4'h2) m_presc = 0;
      else if (base_en) begin
        if (m_presc == DIV - 1) begin m_presc = 0; t = 1; end
        else m_presc++;
      end
      cm = t && m_sec == 59;
      ch = cm && m_min == 59;
      cd = ch && m_hr == 23;
      cmo = cd && m_day >= days_in(m_mon, m_yr);
      cy = cmo && m_mon == 12;
      if (cy) begin
        if (m_yr == 99) begin m_yr = 0; m_cent = 1 - m_cent; end
        else m_yr++;
      end
      if (cmo) m_mon = (m_mon == 12) ? 1 : m_mon + 1;
      if (cd) begin
        m_day = cmo ? 1 : m_day + 1;
        m_wd = (m_wd == 6) ? 0 : m_wd + 1;
      end
      if (ch) m_hr = (m_hr == 23) ? 0 : m_hr + 1;
      if (cm) m_min = (m_min == 59) ? 0 : m_min + 1;
      if (t) m_sec = (m_sec == 59) ? 0 : m_sec + 1;
      if (wr_en) begin
        case (addr)
          4'h2: m_sec = bin(int'(wdata & 8'h7f));
          4'h3: m_min = bin(int'(wdata & 8'h7f));
          4'h4: m_hr  = bin(int'(wdata & 8'h3f));
          4'h5: m_day = bin(int'(wdata & 8'h3f));
          4'h6: m_wd  = int'(wdata & 8'h07);
          4'h7: begin m_mon = bin(int'(wdata & 8'h1f)); m_cent = int'(wdata[7]); end
          4'h8: m_yr  = bin(int'(wdata));
          4'h9: m_al[0] = wdata;
          4'hA: m_al[1] = wdata;
          4'hB: m_al[2] = wdata;
          4'hC: m_al[3] = wdata;
          default: ;
        endcase
      end
      if (wr_en && addr == 4'h1 && !wdata[3]) m_flag = 0;
      if (m && !m_pm) m_flag = 1;
      m_pm = int'(m);
    end
  end

  task automatic check(int act, int exp, string tag);
    total++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    if (rst_n) begin
      check(int'(rdata), int'(exp_read(addr)), tag_of(addr));
      check(int'(irq_n), m_flag ? 0 : 1, "R12");
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic run(int n);
    base_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      addr = 4'(2 + (i % 7));
      cyc();
    end
    base_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] exp, string tag);
    addr = a;
    cyc();
    check(int'(rdata), int'(exp), tag);
  endtask

  task automatic set_time(logic [7:0] h, logic [7:0] mi, logic [7:0] s);
    wr(4'h4, h); wr(4'h3, mi); wr(4'h2, s);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - errs, total);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      total++; errs++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R9: reset values and full map sweep
    for (int a = 0; a < 16; a++) begin
      addr = 4'(a);
      cyc();
    end
    rd(4'h5, 8'h01, "R1 day");
    rd(4'h7, 8'h01, "R1 month");
    rd(4'h9, 8'h80, "R1 alarm");
    check(int'(irq_n), 1, "R1 irq");

    // R2: continuous and sparse base enable
    run(20);
    rd(4'h2, 8'h05, "R2 seconds");
    for (int i = 0; i < 24; i++) begin
      base_en = (i % 3 == 0);
      addr = 4'h2;
      cyc();
    end
    base_en = 1'b0;

    // R3: write seconds mid-second
    wr(4'h2, 8'h00);
    base_en = 1'b1; addr = 4'h2; cyc(); cyc();
    base_en = 1'b0;
    wr(4'h2, 8'h30);
    base_en = 1'b1; addr = 4'h2;
    cyc(); cyc(); cyc();
    check(int'(rdata), 8'h30, "R3 held");
    cyc();
    check(int'(rdata), 8'h31, "R3 advanced");
    base_en = 1'b0;

    // R5 / R6 / R7: non-leap February end, weekday wrap
    wr(4'h8, 8'h23); wr(4'h7, 8'h02); wr(4'h5, 8'h28); wr(4'h6, 8'h06);
    set_time(8'h23, 8'h59, 8'h58);
    run(12);
    rd(4'h5, 8'h01, "R7 nonleap day");
    rd(4'h7, 8'h03, "R7 nonleap month");
    rd(4'h6, 8'h00, "R5 weekday");
    rd(4'h4, 8'h00, "R5 hours");

    // R7: leap February
    wr(4'h8, 8'h24); wr(4'h7, 8'h02); wr(4'h5, 8'h28);
    set_time(8'h23, 8'h59, 8'h58);
    run(12);
    rd(4'h5, 8'h29, "R7 leap day");
    set_time(8'h23, 8'h59, 8'h58);
    run(12);
    rd(4'h5, 8'h01, "R7 leap wrap");
    rd(4'h7, 8'h03, "R7 leap month");

    // R6: 30-day month and 31-day month
    wr(4'h7, 8'h04); wr(4'h5, 8'h30);
    set_time(8'h23, 8'h59, 8'h58);
    run(12);
    rd(4'h7, 8'h05, "R6 april wrap");
    wr(4'h5, 8'h30);
    set_time(8'h23, 8'h59, 8'h58);
    run(12);
    rd(4'h5, 8'h31, "R6 may day31");

    // R8: year and century wrap, twice
    wr(4'h8, 8'h99); wr(4'h7, 8'h12); wr(4'h5, 8'h31);
    set_time(8'h23, 8'h59, 8'h58);
    run(12);
    rd(4'h7, 8'h81, "R8 century set");
    rd(4'h8, 8'h00, "R8 year");
    wr(4'h8, 8'h99); wr(4'h7, 8'h92); wr(4'h5, 8'h31);
    set_time(8'h23, 8'h59, 8'h58);
    run(12);
    rd(4'h7, 8'h01, "R8 century clear");

    // R10 / R11 / R12: alarm with minute and hour enabled
    set_time(8'h10, 8'h29, 8'h58);
    wr(4'h9, 8'h30); wr(4'hA, 8'h10);
    rd(4'h1, 8'h00, "R10 no early flag");
    run(12);
    rd(4'h1, 8'h08, "R10 flag set");
    check(int'(irq_n), 0, "R12 irq low");
    wr(4'h1, 8'h08);
    rd(4'h1, 8'h08, "R11 write one ignored");
    wr(4'h1, 8'h00);
    rd(4'h1, 8'h00, "R11 cleared");
    check(int'(irq_n), 1, "R12 irq released");
    run(8);
    rd(4'h1, 8'h00, "R11 no reassert");

    // R10: disabled hour field with a wrong value is ignored
    wr(4'hA, 8'h85); wr(4'h9, 8'h31);
    set_time(8'h07, 8'h30, 8'h59);
    run(8);
    rd(4'h1, 8'h08, "R10 disabled field ignored");
    wr(4'h1, 8'h00);

    // R10: no field enabled, flag never sets
    wr(4'h9, 8'hB1); wr(4'hB, 8'h80); wr(4'hC, 8'h80);
    set_time(8'h07, 8'h30, 8'h58);
    run(260);
    rd(4'h1, 8'h00, "R10 none enabled");

    finish_up();
  end
endmodule